// File: doc/BRIEF.md
# K-Best Breadth-First Tree-Search MIMO Detector

This block makes a hard decision on the transmitted symbol vector of a spatially multiplexed link. The complex channel is first recast as a real system of dimension M = 2N, which is then brought into upper-triangular form, so each real layer carries one amplitude taken from an 8-level PAM alphabet. The detector takes the triangular matrix R and the rotated receive vector z in signed fixed point. It then searches a tree of symbol hypotheses one layer per level. The search starts at the bottom row of R and climbs one row per level. It never backtracks.

At each level every surviving path is extended by all eight amplitudes, and each extension adds a squared residual to the path's partial Euclidean distance. The K extensions with the smallest accumulated distance become the survivors for the next level. After the top row has been processed, the cheapest survivor is presented with its metric and a one-cycle done pulse. A run is launched with a start pulse, and the matrix and vector are captured at that moment. With the default M = 8 and K = 4, a whole run fits in 40 cycles, which is inside a 64-cycle budget per channel matrix.

Top module: `kbest_detector`

## Requirements
- R1: Amplitude index a (0..7) stands for the real symbol 2a−7. The result gives layer i as a 4-bit two's-complement amplitude at best_sym_o[4i+3:4i].
- R2: R element (i,j) is read from r_mat_i[12(8i+j)+11 : 12(8i+j)], and z_i from z_vec_i[12i+11:12i]; both are signed. Layer i is decided at level 7−i, so row 7 comes first. The increment is (z_i − Σ_{j>i} r(i,j)·s_j − r(i,i)·s_i)², and it is added to the parent's metric. Elements below the diagonal are never read.
- R3: At every level, exactly the K = 4 expansions with the smallest accumulated distance survive. The reported symbols and metric are those of the cheapest final survivor.
- R4: Ties in distance go to the lower candidate index p·8+a, where p is the parent's rank among the survivors (rank 0 is cheapest, and earlier-ranked parents win ties). So an all-zero input gives every layer −7 with metric 0.
- R5: If z equals R·s exactly for some alphabet vector s, and the true path never ties another path at zero, the result is s with metric 0.
- R6: done_o goes high for exactly one cycle, M·(K+1) = 40 cycles after the clock edge that accepts start_i.
- R7: start_i is ignored while a run is in progress. Changing r_mat_i or z_vec_i after acceptance has no effect on that run.
- R8: While reset is active, done_o, best_sym_o and best_metric_o are all zero.
- R9: best_sym_o and best_metric_o change only in the cycle done_o is high. Otherwise they hold their value, including during the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a run; sampled only while idle |
| r_mat_i | input | 768 | Upper-triangular real matrix, 8×8 signed 12-bit |
| z_vec_i | input | 96 | Rotated receive vector, 8 signed 12-bit entries |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| best_sym_o | output | 32 | Decided amplitudes, 4 bits per layer |
| best_metric_o | output | 44 | Accumulated distance of the decided path |

## Verification
Survivor slots, parent indices and level counters are internal, so any fault in them can only show up at the outputs, and only when done_o rises 40 cycles after start. The likely symptoms are a wrong amplitude in some layer, a metric that is too large, or a pulse that comes early, late or twice. Tie ordering is observable only through all-zero inputs or inputs with symmetric residuals, where a wrong winner changes every decided layer. Pruning mistakes usually show up as a metric that differs from the K-best reference on noisy random inputs, so a broad sweep of random cases is needed to expose them.

// File: rtl/kbest_pkg.sv
`timescale 1ns/1ps
package kbest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPAND = 2'd1,
    ST_SELECT = 2'd2
  } kb_state_e;

endpackage

// File: rtl/kbest_branch.sv
`timescale 1ns/1ps
// Expands one survivor over every PAM amplitude at the current row.
module kbest_branch #(
  parameter int NUM_LAYERS = 8,
  parameter int NUM_AMP    = 8,
  parameter int DW         = 12,
  parameter int AW         = 3,
  parameter int LW         = 3,
  parameter int EW         = 20,
  parameter int MW         = 44
) (
  input  logic [NUM_LAYERS*DW-1:0] row_i,
  input  logic signed [DW-1:0]     z_i,
  input  logic [LW-1:0]            lvl_i,
  input  logic [NUM_LAYERS*AW-1:0] sym_i,
  input  logic [MW-1:0]            parent_met_i,
  output logic [NUM_AMP*MW-1:0]    cand_met_o
);

  localparam int SQW = 2 * EW;

  function automatic logic signed [EW-1:0] amp_val(input logic [AW-1:0] idx);
    return EW'(2 * int'(idx) - (NUM_AMP - 1));
  endfunction

  logic signed [EW-1:0] resid;
  logic signed [EW-1:0] diag_e;

  // residual after removing already-decided layers above this row
  always_comb begin
    resid = EW'(z_i);
    for (int j = 0; j < NUM_LAYERS; j++) begin
      if (j > int'(lvl_i)) begin
        resid = resid - EW'($signed(row_i[j*DW +: DW])) * amp_val(sym_i[j*AW +: AW]);
      end
    end
  end

  assign diag_e = EW'($signed(row_i[int'(lvl_i)*DW +: DW]));

  for (genvar a = 0; a < NUM_AMP; a++) begin : g_amp
    logic signed [EW-1:0]  err;
    logic signed [SQW-1:0] sq;
    assign err = resid - diag_e * amp_val(AW'(a));
    assign sq  = SQW'(err) * SQW'(err);
    assign cand_met_o[a*MW +: MW] = parent_met_i + MW'($unsigned(sq));
  end

endmodule

// File: rtl/kbest_argmin.sv
`timescale 1ns/1ps
// Smallest valid metric; the lowest index wins on equal values.
module kbest_argmin #(
  parameter int NCAND = 32,
  parameter int MW    = 44,
  parameter int IW    = 5
) (
  input  logic [NCAND*MW-1:0] met_i,
  input  logic [NCAND-1:0]    vld_i,
  output logic                found_o,
  output logic [IW-1:0]       idx_o,
  output logic [MW-1:0]       min_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    min_o   = '0;
    for (int c = 0; c < NCAND; c++) begin
      if (vld_i[c] && (!found_o || (met_i[c*MW +: MW] < min_o))) begin
        found_o = 1'b1;
        idx_o   = IW'(c);
        min_o   = met_i[c*MW +: MW];
      end
    end
  end

endmodule

// File: rtl/kbest_detector.sv
`timescale 1ns/1ps
module kbest_detector #(
  parameter int NUM_LAYERS = 8,
  parameter int K_SURV     = 4,
  parameter int NUM_AMP    = 8,
  parameter int DW         = 12
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   start_i,
  input  logic [NUM_LAYERS*NUM_LAYERS*DW-1:0]                    r_mat_i,
  input  logic [NUM_LAYERS*DW-1:0]                               z_vec_i,
  output logic                                                   done_o,
  output logic [NUM_LAYERS*($clog2(NUM_AMP)+1)-1:0]              best_sym_o,
  output logic [2*(DW+$clog2(NUM_AMP)+$clog2(NUM_LAYERS)+2)+$clog2(NUM_LAYERS):0] best_metric_o
);

  import kbest_pkg::*;

  localparam int AW  = $clog2(NUM_AMP);
  localparam int SW  = AW + 1;
  localparam int LW  = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;
  localparam int KW  = (K_SURV > 1) ? $clog2(K_SURV) : 1;
  localparam int NC  = K_SURV * NUM_AMP;
  localparam int CW  = $clog2(NC);
  localparam int EW  = DW + AW + $clog2(NUM_LAYERS) + 2;
  localparam int MW  = 2 * EW + $clog2(NUM_LAYERS) + 1;
  localparam int RW  = NUM_LAYERS * NUM_LAYERS * DW;
  localparam int ZW  = NUM_LAYERS * DW;
  localparam int PW  = NUM_LAYERS * AW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // control state
  kb_state_e         state_q, state_d;
  logic [LW-1:0]     lvl_q, lvl_d;
  logic [KW-1:0]     cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [NUM_LAYERS*SW-1:0] best_sym_q, best_sym_d;
  logic [MW-1:0]     best_met_q, best_met_d;

  // datapath storage
  logic [RW-1:0]     r_q;
  logic [ZW-1:0]     z_q;
  logic              cap_en, exp_en, res_en;
  logic [PW-1:0]     cur_sym_q [K_SURV];
  logic [PW-1:0]     cur_sym_d [K_SURV];
  logic [MW-1:0]     cur_met_q [K_SURV];
  logic [MW-1:0]     cur_met_d [K_SURV];
  logic [K_SURV-1:0] cur_vld_q, cur_vld_d;
  logic [PW-1:0]     nxt_sym_q [K_SURV];
  logic [PW-1:0]     nxt_sym_d [K_SURV];
  logic [MW-1:0]     nxt_met_q [K_SURV];
  logic [MW-1:0]     nxt_met_d [K_SURV];
  logic [K_SURV-1:0] nxt_vld_q, nxt_vld_d;
  logic [NC*MW-1:0]  cand_met_q;
  logic [NC-1:0]     cand_vld_q, cand_vld_d;

  // current row view
  logic [NUM_LAYERS*DW-1:0] row_sel;
  logic signed [DW-1:0]     z_sel;
  assign row_sel = r_q[int'(lvl_q)*NUM_LAYERS*DW +: NUM_LAYERS*DW];
  assign z_sel   = $signed(z_q[int'(lvl_q)*DW +: DW]);

  // expansion of all survivors in parallel
  logic [NC*MW-1:0] br_met;
  for (genvar k = 0; k < K_SURV; k++) begin : g_branch
    kbest_branch #(
      .NUM_LAYERS(NUM_LAYERS), .NUM_AMP(NUM_AMP), .DW(DW),
      .AW(AW), .LW(LW), .EW(EW), .MW(MW)
    ) u_branch (
      .row_i        (row_sel),
      .z_i          (z_sel),
      .lvl_i        (lvl_q),
      .sym_i        (cur_sym_q[k]),
      .parent_met_i (cur_met_q[k]),
      .cand_met_o   (br_met[k*NUM_AMP*MW +: NUM_AMP*MW])
    );
  end

  // one survivor picked per select cycle
  logic          sel_found;
  logic [CW-1:0] sel_idx;
  logic [MW-1:0] sel_met;
  kbest_argmin #(.NCAND(NC), .MW(MW), .IW(CW)) u_argmin (
    .met_i   (cand_met_q),
    .vld_i   (cand_vld_q),
    .found_o (sel_found),
    .idx_o   (sel_idx),
    .min_o   (sel_met)
  );

  int            sel_par;
  int            sel_amp;
  logic [PW-1:0] sel_sym;
  always_comb begin
    sel_par = int'(sel_idx) / NUM_AMP;
    sel_amp = int'(sel_idx) % NUM_AMP;
    sel_sym = cur_sym_q[sel_par];
    sel_sym[int'(lvl_q)*AW +: AW] = AW'(sel_amp);
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    lvl_d      = lvl_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    best_sym_d = best_sym_q;
    best_met_d = best_met_q;
    cap_en     = 1'b0;
    exp_en     = 1'b0;
    res_en     = 1'b0;
    cur_sym_d  = cur_sym_q;
    cur_met_d  = cur_met_q;
    cur_vld_d  = cur_vld_q;
    nxt_sym_d  = nxt_sym_q;
    nxt_met_d  = nxt_met_q;
    nxt_vld_d  = nxt_vld_q;
    cand_vld_d = cand_vld_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en    = 1'b1;
          lvl_d     = LW'(NUM_LAYERS - 1);
          cur_vld_d = K_SURV'(1);
          for (int k = 0; k < K_SURV; k++) begin
            cur_sym_d[k] = '0;
            cur_met_d[k] = '0;
          end
          state_d = ST_EXPAND;
        end
      end
      ST_EXPAND: begin
        exp_en = 1'b1;
        for (int c = 0; c < NC; c++) begin
          cand_vld_d[c] = cur_vld_q[c / NUM_AMP];
        end
        nxt_vld_d = '0;
        cnt_d     = '0;
        state_d   = ST_SELECT;
      end
      ST_SELECT: begin
        nxt_sym_d[cnt_q] = sel_sym;
        nxt_met_d[cnt_q] = sel_met;
        nxt_vld_d[cnt_q] = sel_found;
        if (sel_found) cand_vld_d[sel_idx] = 1'b0;
        if (int'(cnt_q) == K_SURV - 1) begin
          cur_sym_d = nxt_sym_d;
          cur_met_d = nxt_met_d;
          cur_vld_d = nxt_vld_d;
          if (lvl_q == '0) begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
            for (int j = 0; j < NUM_LAYERS; j++) begin
              best_sym_d[j*SW +: SW] = SW'(2 * int'(nxt_sym_d[0][j*AW +: AW]) - (NUM_AMP - 1));
            end
            best_met_d = nxt_met_d[0];
          end else begin
            lvl_d   = lvl_q - LW'(1);
            state_d = ST_EXPAND;
          end
        end else begin
          cnt_d = cnt_q + KW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      lvl_q      <= '0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      best_sym_q <= '0;
      best_met_q <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (res_en) begin
        best_sym_q <= best_sym_d;
        best_met_q <= best_met_d;
      end
    end
  end

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      r_q <= r_mat_i;
      z_q <= z_vec_i;
    end
    if (exp_en) cand_met_q <= br_met;
    cand_vld_q <= cand_vld_d;
    cur_sym_q  <= cur_sym_d;
    cur_met_q  <= cur_met_d;
    cur_vld_q  <= cur_vld_d;
    nxt_sym_q  <= nxt_sym_d;
    nxt_met_q  <= nxt_met_d;
    nxt_vld_q  <= nxt_vld_d;
  end

  assign done_o        = done_q;
  assign best_sym_o    = best_sym_q;
  assign best_metric_o = best_met_q;

endmodule

// File: rtl/kbest_detector_chk.sv
`timescale 1ns/1ps
module kbest_detector_chk #(
  parameter int NUM_LAYERS = 8,
  parameter int K_SURV     = 4,
  parameter int DW         = 12,
  parameter int MW         = 44,
  parameter int KW         = 2,
  parameter int SW         = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  start_i,
  input logic                                  done_o,
  input logic [MW-1:0]                         best_metric_o,
  input logic [NUM_LAYERS*SW-1:0]              best_sym_o,
  input kbest_pkg::kb_state_e                  state_q,
  input logic [KW-1:0]                         cnt_q,
  input logic                                  sel_found,
  input logic [MW-1:0]                         sel_met,
  input logic [NUM_LAYERS*NUM_LAYERS*DW-1:0]   r_q,
  input logic [NUM_LAYERS*DW-1:0]              z_q
);

  import kbest_pkg::*;

  localparam int LAT = NUM_LAYERS * (K_SURV + 1);

  logic [15:0] lat_q;
  logic        run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      run_q <= 1'b0;
    end else if (state_q == ST_IDLE && start_i) begin
      lat_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      lat_q <= lat_q + 16'd1;
      if (done_o) run_q <= 1'b0;
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q && lat_q == 16'(LAT)));

  // R7
  captured_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(r_q) && $stable(z_q)));

  // R3
  select_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELECT && cnt_q != '0 && sel_found) |-> (sel_met >= $past(sel_met)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(best_metric_o) && $stable(best_sym_o)));

endmodule

bind kbest_detector kbest_detector_chk #(
  .NUM_LAYERS(NUM_LAYERS), .K_SURV(K_SURV), .DW(DW), .MW(MW), .KW(KW), .SW(SW)
) i_kbest_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .start_i       (start_i),
  .done_o        (done_o),
  .best_metric_o (best_metric_o),
  .best_sym_o    (best_sym_o),
  .state_q       (state_q),
  .cnt_q         (cnt_q),
  .sel_found     (sel_found),
  .sel_met       (sel_met),
  .r_q           (r_q),
  .z_q           (z_q)
);

// File: tb/test_kbest_detector.sv
`timescale 1ns/1ps
module test_kbest_detector;

  localparam int NL  = 8;
  localparam int KS  = 4;
  localparam int NA  = 8;
  localparam int DW  = 12;
  localparam int SW  = 4;
  localparam int EW  = DW + 3 + 3 + 2;
  localparam int MW  = 2 * EW + 3 + 1;
  localparam int LAT = NL * (KS + 1);

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  start_i;
  logic [NL*NL*DW-1:0]   r_mat_i;
  logic [NL*DW-1:0]      z_vec_i;
  logic                  done_o;
  logic [NL*SW-1:0]      best_sym_o;
  logic [MW-1:0]         best_metric_o;

  always #4 clk = ~clk;

  kbest_detector i_kbest_detector (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .r_mat_i(r_mat_i),
    .z_vec_i(z_vec_i), .done_o(done_o), .best_sym_o(best_sym_o),
    .best_metric_o(best_metric_o)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  longint rm [NL][NL];
  longint zv [NL];
  int     exp_sym [NL];
  longint exp_met;
  longint last_met;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // K-best reference written from R2..R4
  task automatic ref_model();
    int     ps [KS][NL];
    longint pm [KS];
    bit     pv [KS];
    int     ns [KS][NL];
    longint nm [KS];
    bit     nv [KS];
    longint cm [KS*NA];
    bit     cv [KS*NA];
    for (int k = 0; k < KS; k++) begin
      pv[k] = (k == 0); pm[k] = 0;
      for (int j = 0; j < NL; j++) ps[k][j] = 0;
    end
    for (int lv = NL - 1; lv >= 0; lv--) begin
      for (int p = 0; p < KS; p++) begin
        longint b;
        b = zv[lv];
        for (int j = lv + 1; j < NL; j++) b -= rm[lv][j] * (2 * ps[p][j] - 7);
        for (int a = 0; a < NA; a++) begin
          longint e;
          e = b - rm[lv][lv] * (2 * a - 7);
          cm[p*NA+a] = pm[p] + e * e;
          cv[p*NA+a] = pv[p];
        end
      end
      for (int k = 0; k < KS; k++) begin
        int bi;
        bi = -1;
        for (int c = 0; c < KS*NA; c++)
          if (cv[c] && (bi < 0 || cm[c] < cm[bi])) bi = c;
        nv[k] = (bi >= 0);
        if (bi >= 0) begin
          for (int j = 0; j < NL; j++) ns[k][j] = ps[bi/NA][j];
          ns[k][lv] = bi % NA;
          nm[k] = cm[bi];
          cv[bi] = 1'b0;
        end
      end
      for (int k = 0; k < KS; k++) begin
        pv[k] = nv[k]; pm[k] = nm[k];
        for (int j = 0; j < NL; j++) ps[k][j] = ns[k][j];
      end
    end
    for (int j = 0; j < NL; j++) exp_sym[j] = 2 * ps[0][j] - 7;
    exp_met = pm[0];
  endtask

  task automatic apply();
    for (int i = 0; i < NL; i++) begin
      z_vec_i[i*DW +: DW] = DW'(zv[i]);
      for (int j = 0; j < NL; j++) r_mat_i[(i*NL+j)*DW +: DW] = DW'(rm[i][j]);
    end
  endtask

  // inject: pulse start with other data mid-run; hold: check previous result mid-run
  task automatic run_case(input string tag, input bit inject, input bit hold);
    int n;
    bit seen;
    ref_model();
    apply();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 200) begin
      @(negedge clk); n++;
      if (inject && n == 10) begin
        r_mat_i = '0;
        z_vec_i = {NL{12'sd1500}};
        start_i = 1'b1;
      end
      if (inject && n == 11) start_i = 1'b0;
      if (hold && n == 20) chk({tag, " R9 result held mid-run"}, longint'(best_metric_o), last_met);
      if (done_o) seen = 1'b1;
    end
    chk({tag, " R6 done latency"}, longint'(n), longint'(LAT));
    chk({tag, " R3 metric"}, longint'(best_metric_o), exp_met);
    for (int j = 0; j < NL; j++)
      chk($sformatf("%s R1 layer %0d amplitude", tag, j),
          longint'($signed(best_sym_o[j*SW +: SW])), longint'(exp_sym[j]));
    last_met = longint'(best_metric_o);
    @(negedge clk);
    chk({tag, " R6 single pulse"}, longint'(done_o), 0);
  endtask

  task automatic rand_matrix(input int dmax, input int omax);
    for (int i = 0; i < NL; i++)
      for (int j = 0; j < NL; j++) begin
        if (j == i)     rm[i][j] = longint'($urandom_range(dmax, 1));
        else if (j > i) rm[i][j] = longint'($urandom_range(2*omax, 0)) - omax;
        else            rm[i][j] = longint'($urandom_range(4095, 0)) - 2048;
      end
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int s [NL];
    rst_n = 1'b0; start_i = 1'b0; r_mat_i = '0; z_vec_i = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 done in reset", longint'(done_o), 0);
    chk("R8 metric in reset", longint'(best_metric_o), 0);
    chk("R8 symbols in reset", longint'(best_sym_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_met = 0;

    // R4 all-zero input: every tie resolves to index 0
    for (int i = 0; i < NL; i++) begin
      zv[i] = 0;
      for (int j = 0; j < NL; j++) rm[i][j] = 0;
    end
    ref_model();
    chk("R4 zero-input metric model", exp_met, 0);
    chk("R4 zero-input amplitude model", longint'(exp_sym[3]), -7);
    run_case("R4 zero", 1'b0, 1'b0);

    // R4 symmetric residual: +-1 tie picks -1, metric 8*4 (R2)
    for (int i = 0; i < NL; i++) rm[i][i] = 2;
    ref_model();
    chk("R4 symmetric metric model", exp_met, 32);
    chk("R4 symmetric amplitude model", longint'(exp_sym[0]), -1);
    run_case("R4 R2 symmetric", 1'b0, 1'b1);

    // R5 noiseless cases
    for (int t = 0; t < 6; t++) begin
      rand_matrix(100, 20);
      for (int j = 0; j < NL; j++) s[j] = 2 * int'($urandom_range(7, 0)) - 7;
      for (int i = 0; i < NL; i++) begin
        zv[i] = 0;
        for (int j = i; j < NL; j++) zv[i] += rm[i][j] * s[j];
      end
      ref_model();
      chk($sformatf("R5 noiseless %0d metric", t), exp_met, 0);
      for (int j = 0; j < NL; j++)
        chk($sformatf("R5 noiseless %0d layer %0d", t, j), longint'(exp_sym[j]), longint'(s[j]));
      run_case($sformatf("R5 noiseless %0d", t), 1'b0, 1'b0);
    end

    // R3 R2 noisy random cases against the K-best reference
    for (int t = 0; t < 40; t++) begin
      rand_matrix((t % 2) ? 300 : 40, (t % 3) ? 100 : 300);
      for (int i = 0; i < NL; i++) zv[i] = longint'($urandom_range(4095, 0)) - 2048;
      run_case($sformatf("R3 random %0d", t), 1'b0, (t % 5) == 0);
    end

    // R3 extreme magnitudes
    for (int i = 0; i < NL; i++) begin
      zv[i] = (i % 2) ? 2047 : -2048;
      for (int j = 0; j < NL; j++) rm[i][j] = (j == i) ? 2047 : ((j > i) ? -2048 : 2047);
    end
    run_case("R3 extreme", 1'b0, 1'b0);

    // R7 start and new data during a run are ignored
    rand_matrix(200, 80);
    for (int i = 0; i < NL; i++) zv[i] = longint'($urandom_range(4095, 0)) - 2048;
    run_case("R7 busy start", 1'b1, 1'b0);

    // R9 result held while idle
    repeat (15) @(negedge clk);
    chk("R9 result held idle", longint'(best_metric_o), last_met);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule